// File: doc/BRIEF.md
# Two-Digit Decimal Countdown with Start/Stop Toggle

This block is a decimal down counter that runs from 99 to 00, shown as two BCD digits, each meant for an external seven-segment decoder. A single start/stop button controls it. Each button press flips an internal run flag. While the flag is set, the count drops by one on every timebase tick. When the flag is clear, ticks are ignored.

When the count reaches 00, the block clears the run flag on its own and stays halted. Further button presses at 00 do nothing. Only a load, or a reset, restores the count to 99. The load also leaves the counter paused, so it waits for the next press.

The button arrives as a one-cycle pulse that has already been debounced. The timebase arrives as a one-cycle enable. Both act as synchronous enables; neither one gates the clock.

Top module: `bcd_countdown_toggle`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the digits read tens=9 and units=9, `done` is low and the counter is paused.
- R2: A `btn` pulse while the count is not 00 flips the run flag. One pulse starts a paused counter, and the next pulse pauses it again.
- R3: The count changes only on a cycle where the run flag is set and `tick` is high. Ticks while paused leave both digits unchanged.
- R4: Each counting step lowers the value by exactly one. When units is 0, units becomes 9 and tens drops by one in the same step.
- R5: When the count reaches 00, the run flag clears and the count stays at 00 for any later ticks.
- R6: A `btn` pulse while the count is 00 has no effect: later ticks leave the count at 00.
- R7: `load` sets the count to 99 and clears the run flag. It takes priority over `btn` and `tick` in the same cycle.
- R8: `done` is high exactly when both digits are 0.
- R9: Each digit output always holds a value from 0 to 9.
- R10: If a `btn` pulse arrives in the same cycle as the step from 01 to 00, the run flag still ends up clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; presets 99 and pauses |
| btn | input | 1 | One-cycle debounced start/stop press |
| tick | input | 1 | One-cycle timebase enable |
| load | input | 1 | Synchronous preset to 99; also pauses |
| tens | output | 4 | Tens digit, BCD |
| units | output | 4 | Units digit, BCD |
| done | output | 1 | High when the count is 00 |

## Verification
The run flag has no output of its own, so the bench exposes it through the count. A wrong flag value shows up at the digits on the first tick that follows: the count either moves when it should hold, or holds when it should move. The bench therefore supplies ticks after every button, load and terminal-count event, and compares the digits and `done` with a behavioural model on every cycle. A wrong borrow between the two digits shows up at the next step from units 0. Running the full countdown reaches every such step.

// File: rtl/bcd_countdown_toggle.sv
module bcd_countdown_toggle #(
  parameter int PRESET_TENS  = 9,
  parameter int PRESET_UNITS = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn,
  input  logic       tick,
  input  logic       load,
  output logic [3:0] tens,
  output logic [3:0] units,
  output logic       done
);
  localparam logic [3:0] PT  = 4'(PRESET_TENS);
  localparam logic [3:0] PU  = 4'(PRESET_UNITS);
  localparam logic [3:0] TOP = 4'd9;

  logic run;
  logic at_zero, step, last_step, units_wrap;

  assign at_zero    = (tens == 4'd0) && (units == 4'd0);
  assign step       = run && tick && !at_zero;
  assign units_wrap = (units == 4'd0);
  assign last_step  = step && (tens == 4'd0) && (units == 4'd1);
  assign done       = at_zero;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      tens  <= PT;
      units <= PU;
    end else if (step) begin
      units <= units_wrap ? TOP : units - 4'd1;
      if (units_wrap) tens <= tens - 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load)           run <= 1'b0;
    else if (last_step)        run <= 1'b0;
    else if (btn && !at_zero)  run <= ~run;
  end

  assert_bcd_range_R9: assert property (@(posedge clk) disable iff (rst)
    (tens <= 4'd9) && (units <= 4'd9));

  assert_paused_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !(run && tick)) |=> $stable({tens, units}));

  assert_units_borrow_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && run && tick && units == 4'd0 && tens != 4'd0) |=> (units == 4'd9));

  assert_zero_halts_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && at_zero) |=> (at_zero && !run));

  assert_load_preset_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (tens == PT && units == PU && !run));

  assert_last_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (!load && run && tick && tens == 4'd0 && units == 4'd1) |=> !run);
endmodule

// File: tb/sim_bcd_countdown_toggle.sv
`timescale 1ns/1ps
module sim_bcd_countdown_toggle;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0, tick = 1'b0, load = 1'b0;
  logic [3:0] tens, units;
  logic done;

  int checks = 0;
  int errors = 0;
  int mcnt = 99;
  bit mrun = 1'b0;

  always #2 clk = ~clk;

  bcd_countdown_toggle u0 (
    .clk(clk), .rst(rst), .btn(btn), .tick(tick), .load(load),
    .tens(tens), .units(units), .done(done)
  );

  task automatic compare(input string tag);
    int et, eu;
    bit ed;
    et = mcnt / 10;
    eu = mcnt % 10;
    ed = (mcnt == 0);
    checks++;
    if (int'(tens) != et || int'(units) != eu || done != ed) begin
      errors++;
      $display("FAIL %s: got %0d%0d done=%0b, expected %0d%0d done=%0b",
               tag, tens, units, done, et, eu, ed);
    end
  endtask

  task automatic cyc(input bit b, input bit t, input bit l, input string tag);
    bit nr;
    btn = b; tick = t; load = l;
    @(posedge clk);
    if (l) begin
      mcnt = 99; mrun = 1'b0;
    end else begin
      nr = mrun;
      if (b && mcnt != 0) nr = !mrun;
      if (mrun && t && mcnt != 0) begin
        mcnt--;
        if (mcnt == 0) nr = 1'b0;
      end
      mrun = nr;
    end
    @(negedge clk);
    btn = 1'b0; tick = 1'b0; load = 1'b0;
    compare(tag);
  endtask

  task automatic run_all;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    compare("R1 after reset");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, "R3 tick while paused");
    cyc(1, 0, 0, "R2 start press");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, "R4 step");
    cyc(1, 1, 0, "R2 pause press with tick");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, "R3 paused ticks");
    cyc(1, 0, 0, "R2 resume press");
    for (int i = 0; i < 300; i++) cyc(0, (i % 3) != 1, 0, "R4 R8 countdown");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, "R5 ticks at zero");
    cyc(1, 0, 0, "R6 press at zero");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, "R6 ticks after press at zero");
    cyc(1, 1, 1, "R7 load with press and tick");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R7 paused after load");
    cyc(1, 0, 0, "R2 start");
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, "R4 step");
    cyc(0, 1, 1, "R7 load while running");
    cyc(0, 1, 0, "R7 run cleared by load");
    cyc(1, 0, 0, "R2 start");
    for (int i = 0; i < 98; i++) cyc(0, 1, 0, "R4 to 01");
    cyc(1, 1, 0, "R10 press on last step");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R10 halted");
    cyc(0, 0, 1, "R7 reload");
    cyc(1, 0, 0, "R2 start");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R4 step");
    rst = 1'b1; mcnt = 99; mrun = 1'b0;
    @(negedge clk);
    compare("R1 mid-run reset");
    rst = 1'b0;
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R1 paused after reset");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule